// File: doc/BRIEF.md
# Driver Impedance Calibration Stepper

This block is the digital half of an output-driver impedance tracking loop. The driver's strength comes from two binary-weighted transistor banks, one pulling up and one pulling down. Each bank is selected by a code word. An external measurement compares each bank against a reference and reports one of three things: the code should rise, it should fall, or it should stay. In that measurement the reference resistor is five times the wanted output impedance, and it lies in a range of roughly 150 to 300 ohms. Those comparator results arrive here as plain digital inputs.

A free-running cycle timer opens an evaluation window once every `EVAL_INTERVAL` clocks. In that cycle, each side's pending (target) code moves by at most one LSB, and it saturates at the ends of its range. A pending code reaches the driver only while that half of the driver is idle. The pull-up code may change while the pad drives a 0 or floats. The pull-down code may change while the pad drives a 1 or floats. An edge in progress therefore never sees its drive strength change. A pending code is held as long as needed, across any number of later evaluations.

Top module: `drv_imp_cal`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it is released, both `pu_code_o` and `pd_code_o` equal mid-scale (bit CODE_W-1 set, all others clear; 32 for 6 bits).
- R2: The comparator inputs are sampled only at the clock edge that closes each window of `EVAL_INTERVAL` cycles. That is the k-th rising edge after reset release, for every k that is a multiple of `EVAL_INTERVAL`. Values present at any other edge have no effect on either code.
- R3: At an evaluation, a side whose inc input is 1 and whose dec input is 0 raises its pending code by one. With dec 1 and inc 0, it lowers the pending code by one. With both inputs equal, the pending code is kept.
- R4: A pending code at all-ones does not rise any further, and a pending code at zero does not fall any further. Neither code wraps.
- R5: `drv_state_i` encodes 00 = high-Z, 01 = driving 0, 10 = driving 1, 11 = unknown. The pull-up output takes its pending code at a rising edge only if `drv_state_i` is 00 or 01 at that edge; otherwise it holds its value.
- R6: The pull-down output takes its pending code at a rising edge only if `drv_state_i` is 00 or 10 at that edge; otherwise it holds its value.
- R7: With `drv_state_i` = 11, neither output changes.
- R8: A pending code that is blocked is kept through later evaluations. At the first allowed edge, the output jumps straight to the latest pending value. An evaluation result reaches an unblocked output one rising edge after the evaluation edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pu_inc_i | input | 1 | Pull-up comparator: raise code |
| pu_dec_i | input | 1 | Pull-up comparator: lower code |
| pd_inc_i | input | 1 | Pull-down comparator: raise code |
| pd_dec_i | input | 1 | Pull-down comparator: lower code |
| drv_state_i | input | 2 | Pad state: 00 high-Z, 01 low, 10 high, 11 unknown |
| pu_code_o | output | CODE_W | Active pull-up bank code |
| pd_code_o | output | CODE_W | Active pull-down bank code |

## Verification
A timer that is off by one edge puts the evaluation in the wrong cycle. The output then moves one window early or late, or it reacts to inputs that were applied only between windows. The next evaluation shows this directly. A corrupt pending register cannot be seen while its half of the driver is busy. It appears in full at the first idle edge, because the output then jumps to it. For that reason the directed tests hold each side blocked across several evaluations before they release it. A saturation fault shows as a wrap from all-ones to zero, or from zero to all-ones, at the evaluation after the code reaches its end.

// File: rtl/drv_imp_cal_pkg.sv
package drv_imp_cal_pkg;

   // Pad activity as reported by the output stage
   typedef enum logic [1:0] {
      DRV_HIZ  = 2'b00,
      DRV_LOW  = 2'b01,
      DRV_HIGH = 2'b10,
      DRV_UNK  = 2'b11
   } drv_state_t;

   // Which half of the driver a code controls
   typedef enum logic {
      SIDE_PU = 1'b0,
      SIDE_PD = 1'b1
   } side_t;

   localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/dic_interval_timer.sv
module dic_interval_timer #(
   parameter int unsigned INTERVAL = 1024
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic eval_o
);
   localparam int unsigned CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam bit IS_POW2 = (INTERVAL == (1 << CNT_W));

   if (INTERVAL < 2) begin : g_bad_interval
      $error("INTERVAL must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   if (IS_POW2) begin : g_wrap
      // power of two: the counter wraps by itself
      always_ff @(posedge clk_i) begin
         if (!rst_ni) cnt_q <= '0;
         else         cnt_q <= cnt_q + ONE;
      end
      assign eval_o = &cnt_q;
   end else begin : g_cmp
      always_ff @(posedge clk_i) begin
         if (!rst_ni)            cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                    cnt_q <= cnt_q + ONE;
      end
      assign eval_o = (cnt_q == LAST);
   end
endmodule

// File: rtl/dic_code_stepper.sv
module dic_code_stepper #(
   parameter int unsigned CODE_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              eval_i,
   input  logic              inc_i,
   input  logic              dec_i,
   output logic [CODE_W-1:0] tgt_o
);
   localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};
   localparam logic [CODE_W-1:0] MAXC = '1;
   localparam logic [CODE_W-1:0] MINC = '0;
   localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);

   logic              up_ok, dn_ok;
   logic [CODE_W-1:0] tgt_q;

   assign up_ok = inc_i && !dec_i && (tgt_q != MAXC);
   assign dn_ok = dec_i && !inc_i && (tgt_q != MINC);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         tgt_q <= MID;
      end else if (eval_i) begin
         if (up_ok)      tgt_q <= tgt_q + ONE;
         else if (dn_ok) tgt_q <= tgt_q - ONE;
      end
   end

   assign tgt_o = tgt_q;
endmodule

// File: rtl/dic_apply_gate.sv
module dic_apply_gate
   import drv_imp_cal_pkg::*;
#(
   parameter int unsigned CODE_W = 6,
   parameter side_t       SIDE   = SIDE_PU
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  drv_state_t        state_i,
   input  logic [CODE_W-1:0] tgt_i,
   output logic [CODE_W-1:0] code_o
);
   localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

   logic              idle;
   logic [CODE_W-1:0] code_q;

   if (SIDE == SIDE_PU) begin : g_pu
      // pull-up bank is off while the pad is low or floating
      assign idle = (state_i == DRV_HIZ) || (state_i == DRV_LOW);
   end else begin : g_pd
      // pull-down bank is off while the pad is high or floating
      assign idle = (state_i == DRV_HIZ) || (state_i == DRV_HIGH);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)   code_q <= MID;
      else if (idle) code_q <= tgt_i;
   end

   assign code_o = code_q;
endmodule

// File: rtl/drv_imp_cal.sv
module drv_imp_cal
   import drv_imp_cal_pkg::*;
#(
   parameter int unsigned CODE_W        = 6,
   parameter int unsigned EVAL_INTERVAL = 1024
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pu_inc_i,
   input  logic              pu_dec_i,
   input  logic              pd_inc_i,
   input  logic              pd_dec_i,
   input  logic [1:0]        drv_state_i,
   output logic [CODE_W-1:0] pu_code_o,
   output logic [CODE_W-1:0] pd_code_o
);
   if (CODE_W < 2 || CODE_W > 16) begin : g_bad_width
      $error("CODE_W must lie in 2..16");
   end

   logic                            eval;
   drv_state_t                      state;
   logic [NUM_SIDES-1:0]            inc_v, dec_v;
   logic [NUM_SIDES-1:0][CODE_W-1:0] tgt_v, code_v;
   logic [CODE_W-1:0]               pu_tgt, pd_tgt;

   assign state = drv_state_t'(drv_state_i);
   assign inc_v = {pd_inc_i, pu_inc_i};
   assign dec_v = {pd_dec_i, pu_dec_i};

   dic_interval_timer #(
      .INTERVAL(EVAL_INTERVAL)
   ) i_timer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .eval_o(eval)
   );

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      dic_code_stepper #(
         .CODE_W(CODE_W)
      ) i_step (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .eval_i(eval),
         .inc_i (inc_v[s]),
         .dec_i (dec_v[s]),
         .tgt_o (tgt_v[s])
      );

      dic_apply_gate #(
         .CODE_W(CODE_W),
         .SIDE  ((s == 0) ? SIDE_PU : SIDE_PD)
      ) i_gate (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .state_i(state),
         .tgt_i  (tgt_v[s]),
         .code_o (code_v[s])
      );
   end

   assign pu_tgt    = tgt_v[0];
   assign pd_tgt    = tgt_v[1];
   assign pu_code_o = code_v[0];
   assign pd_code_o = code_v[1];
endmodule

// File: rtl/drv_imp_cal_chk.sv
module drv_imp_cal_chk #(
   parameter int unsigned CODE_W = 6
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              eval_i,
   input logic              pu_inc_i,
   input logic              pu_dec_i,
   input logic              pd_inc_i,
   input logic              pd_dec_i,
   input logic [1:0]        drv_state_i,
   input logic [CODE_W-1:0] pu_tgt_i,
   input logic [CODE_W-1:0] pd_tgt_i,
   input logic [CODE_W-1:0] pu_code_o,
   input logic [CODE_W-1:0] pd_code_o
);
   localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);
   localparam logic [CODE_W-1:0] MAXC = '1;

   // R2
   tgt_only_on_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eval_i |=> ($stable(pu_tgt_i) && $stable(pd_tgt_i)));

   // R3
   pu_one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eval_i |=> (pu_tgt_i == $past(pu_tgt_i)) || (pu_tgt_i == $past(pu_tgt_i) + ONE)
                 || (pu_tgt_i == $past(pu_tgt_i) - ONE));

   // R3
   pd_one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eval_i |=> (pd_tgt_i == $past(pd_tgt_i)) || (pd_tgt_i == $past(pd_tgt_i) + ONE)
                 || (pd_tgt_i == $past(pd_tgt_i) - ONE));

   // R4
   pu_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && pu_inc_i && !pu_dec_i && pu_tgt_i == MAXC) |=> (pu_tgt_i == MAXC));

   // R4
   pd_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && pd_dec_i && !pd_inc_i && pd_tgt_i == '0) |=> (pd_tgt_i == '0));

   // R5
   pu_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_state_i == 2'b10 || drv_state_i == 2'b11) |=> $stable(pu_code_o));

   // R6
   pd_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_state_i == 2'b01 || drv_state_i == 2'b11) |=> $stable(pd_code_o));

   // R8
   idle_catch_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_state_i == 2'b00) |=> (pu_code_o == $past(pu_tgt_i)) && (pd_code_o == $past(pd_tgt_i)));
endmodule

bind drv_imp_cal drv_imp_cal_chk #(.CODE_W(CODE_W)) i_drv_imp_cal_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .eval_i     (eval),
   .pu_inc_i   (pu_inc_i),
   .pu_dec_i   (pu_dec_i),
   .pd_inc_i   (pd_inc_i),
   .pd_dec_i   (pd_dec_i),
   .drv_state_i(drv_state_i),
   .pu_tgt_i   (pu_tgt),
   .pd_tgt_i   (pd_tgt),
   .pu_code_o  (pu_code_o),
   .pd_code_o  (pd_code_o)
);

// File: tb/test_drv_imp_cal.sv
module test_drv_imp_cal;
   localparam int CLK_PERIOD = 10;
   localparam int IV         = 6;
   localparam int W          = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pu_inc = 1'b0, pu_dec = 1'b0, pd_inc = 1'b0, pd_dec = 1'b0;
   logic [1:0]   st = 2'b00;
   logic [W-1:0] pu_code, pd_code;
   int           ecnt = 0;
   int           n_chk = 0;
   int           n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // rising edges since reset release
   always @(posedge clk) begin
      if (!rst_n) ecnt <= 0;
      else        ecnt <= ecnt + 1;
   end

   drv_imp_cal #(.CODE_W(W), .EVAL_INTERVAL(IV)) i_drv_imp_cal (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .pu_inc_i   (pu_inc),
      .pu_dec_i   (pu_dec),
      .pd_inc_i   (pd_inc),
      .pd_dec_i   (pd_dec),
      .drv_state_i(st),
      .pu_code_o  (pu_code),
      .pd_code_o  (pd_code)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic both(input string req, input int pu_e, input int pd_e);
      chk({req, " pull-up"}, int'(pu_code), pu_e);
      chk({req, " pull-down"}, int'(pd_code), pd_e);
   endtask

   // present comparator results across exactly one evaluation edge
   task automatic do_eval(input logic a, input logic b, input logic c, input logic d);
      while ((ecnt % IV) != IV - 1) @(negedge clk);
      {pu_inc, pu_dec, pd_inc, pd_dec} = {a, b, c, d};
      @(negedge clk);
      {pu_inc, pu_dec, pd_inc, pd_dec} = 4'b0000;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      both("R1 during reset", 32, 32);
      rst_n = 1'b1;
      @(negedge clk);
      both("R1 after release", 32, 32);
   endtask

   task automatic t_off_window();
      st = 2'b00;
      while ((ecnt % IV) != 1) @(negedge clk);
      {pu_inc, pu_dec, pd_inc, pd_dec} = 4'b1010;
      repeat (IV - 3) @(negedge clk);
      {pu_inc, pu_dec, pd_inc, pd_dec} = 4'b0000;
      repeat (4) @(negedge clk);
      both("R2 inputs between windows ignored", 32, 32);
   endtask

   task automatic t_step();
      st = 2'b00;
      do_eval(1'b1, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      both("R3 single step up/down", 33, 31);
      do_eval(1'b1, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      both("R3 conflicting or idle inputs hold", 33, 31);
   endtask

   task automatic t_gate();
      st = 2'b10;
      do_eval(1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      chk("R5 pull-up held while driving 1", int'(pu_code), 33);
      chk("R6 pull-down applied while driving 1", int'(pd_code), 32);
      repeat (3) @(negedge clk);
      chk("R5 pull-up still held", int'(pu_code), 33);
      st = 2'b01;
      @(negedge clk);
      chk("R5 pull-up applied while driving 0", int'(pu_code), 34);
      do_eval(1'b0, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      chk("R6 pull-down held while driving 0", int'(pd_code), 32);
      chk("R5 pull-up unaffected", int'(pu_code), 34);
      st = 2'b00;
      @(negedge clk);
      chk("R6 pull-down applied while high-Z", int'(pd_code), 33);
   endtask

   task automatic t_unknown_and_pending();
      st = 2'b11;
      do_eval(1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      both("R7 unknown state blocks both", 34, 33);
      do_eval(1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      both("R8 pending kept across evaluations", 34, 33);
      st = 2'b00;
      @(negedge clk);
      both("R8 jump to latest pending", 36, 35);
   endtask

   task automatic t_saturate();
      st = 2'b00;
      for (int i = 0; i < 40; i++) do_eval(1'b1, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      both("R4 saturation at ends", 63, 0);
      do_eval(1'b1, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      both("R4 no wrap past ends", 63, 0);
      do_eval(1'b0, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      both("R3 step back from ends", 62, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_off_window();
      t_step();
      t_gate();
      t_unknown_and_pending();
      t_saturate();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule